// File: doc/BRIEF.md
# Dual Programmable Baud Rate Generator

This block derives two rate enables, one for the transmit direction and one for the receive direction, from a single system clock. A single time-constant divider is shared by both directions. It counts system cycles and produces a base tick. Each direction then feeds that base tick into its own power-of-two prescaler. The output period of a direction is therefore the time constant multiplied by two raised to that direction's exponent.

Software-visible state is limited to three write-only fields, selected by `cfg_sel`. Each direction drives two outputs. The first is a strobe that lasts one system cycle and marks the last cycle of every output period. The second is a rate clock that is high during the first half of each period. A new setting never cuts short the count already running: each field is taken up only at the terminal count of the counter it controls.

Top module: `twin_rate_gen`

## Requirements
- R1: The period of each direction, in system cycles, is N = T * 2^E. T is the time constant and E is that direction's effective exponent.
- R2: The time constant is written with `cfg_sel` = 0 from `cfg_wdata[7:0]`. A value of 1 to 255 means itself, and a value of 0 means 256.
- R3: The transmit exponent is written with `cfg_sel` = 1 and the receive exponent with `cfg_sel` = 2, both from `cfg_wdata[3:0]`. Values 10 to 15 act as 9.
- R4: The two directions are independent. Writing one direction's exponent leaves the other direction's period unchanged.
- R5: Each strobe is high for exactly one system cycle per period, so consecutive strobes are N cycles apart. With N = 1 the strobe is high on every cycle.
- R6: Each rate clock is high for the first ceil(N/2) cycles of a period and low for the rest, so the strobe cycle is low whenever N > 1. With N = 1 the rate clock stays high.
- R7: A time-constant write takes effect at the shared divider's next terminal count. The divider cycle already in progress completes with the old value.
- R8: An exponent write takes effect when that direction's current output period ends.
- R9: While the synchronous reset `rst` is high, all four outputs are low. Reset also returns T to 256 and both exponents to 0 and restarts the counters. The first strobe of each direction then appears 255 cycles after the first cycle in which `rst` is low.
- R10: A write with `cfg_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Field write enable |
| cfg_sel | input | 2 | Field select: 0 time constant, 1 transmit exponent, 2 receive exponent, 3 none |
| cfg_wdata | input | 8 | Write data |
| tx_tick | output | 1 | Transmit rate strobe |
| tx_clk | output | 1 | Transmit rate clock |
| rx_tick | output | 1 | Receive rate strobe |
| rx_clk | output | 1 | Receive rate clock |

## Verification
Some behaviours are checked by the assertions on every cycle:
- strobes fire only on a divider terminal count;
- the rate clock is low in the strobe cycle and high in the cycle after it;
- the active time constant changes only at a divider terminal, and the active exponent only at its own strobe;
- active exponents never exceed 9;
- outputs stay low in reset.

Other behaviours only the bench scenarios can show: exact period lengths and high-time counts for many field values, the encoding of 0 as 256, exponent clamping, independence of the two directions, the length of the period in progress when a field changes, the ignored select value, and the restored defaults after reset.

// File: rtl/twin_rate_pkg.sv
package twin_rate_pkg;
  localparam int TC_W    = 8;
  localparam int EXP_W   = 4;
  localparam int EXP_MAX = 9;
  localparam int SEL_W   = 2;
  localparam int N_DIR   = 2;
  localparam int RATIO_W = TC_W + 1;
  localparam int PRE_W   = EXP_MAX;
  localparam logic [TC_W-1:0] TC_RESET = '0;

  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [EXP_W-1:0]   exp_t;
  typedef logic [PRE_W-1:0]   pre_t;

  // Field value to divide ratio: zero stands for 2^TC_W.
  function automatic ratio_t tc_ratio(input logic [TC_W-1:0] f);
    if (f == '0) return ratio_t'(1) << TC_W;
    return ratio_t'(f);
  endfunction

  function automatic exp_t exp_clamp(input exp_t e);
    return (e > exp_t'(EXP_MAX)) ? exp_t'(EXP_MAX) : e;
  endfunction

  // Last prescaler position for exponent e: 2^e - 1.
  function automatic pre_t pre_last(input exp_t e);
    pre_t ones;
    ones = '1;
    return ones >> (PRE_W - int'(e));
  endfunction

  // Top position bit of the prescaler: set during the second half of a period.
  function automatic pre_t pre_half_mask(input exp_t e);
    return pre_last(e) ^ (pre_last(e) >> 1);
  endfunction
endpackage

// File: rtl/twin_rate_cfg.sv
module twin_rate_cfg
  import twin_rate_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [SEL_W-1:0]       sel,
  input  logic [TC_W-1:0]        wdata,
  output logic [TC_W-1:0]        tc_stage,
  output exp_t [N_DIR-1:0]       exp_stage
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_stage  <= TC_RESET;
      exp_stage <= '0;
    end else if (we) begin
      if (sel == '0) tc_stage <= wdata;
      for (int d = 0; d < N_DIR; d++) begin
        if (sel == SEL_W'(d + 1)) exp_stage[d] <= wdata[EXP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/twin_tc_div.sv
module twin_tc_div
  import twin_rate_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [TC_W-1:0] tc_stage,
  output logic            base_tick,
  output logic            upper_half,
  output ratio_t          tc_act
);
  ratio_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_act <= tc_ratio(TC_RESET);
      cnt    <= tc_ratio(TC_RESET) - ratio_t'(1);
    end else if (cnt == '0) begin
      tc_act <= tc_ratio(tc_stage);
      cnt    <= tc_ratio(tc_stage) - ratio_t'(1);
    end else begin
      cnt <= cnt - ratio_t'(1);
    end
  end

  assign base_tick  = (cnt == '0);
  // Count runs downward, so the first ceil(T/2) values are the upper ones.
  assign upper_half = (cnt >= (tc_act >> 1));
endmodule

// File: rtl/twin_pow2_pre.sv
module twin_pow2_pre
  import twin_rate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic base_tick,
  input  logic upper_half,
  input  exp_t exp_stage,
  output logic tick,
  output logic rate_clk,
  output exp_t exp_act
);
  pre_t pos;
  logic period_end;

  assign period_end = base_tick && (pos == pre_last(exp_act));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos     <= '0;
      exp_act <= '0;
    end else if (period_end) begin
      pos     <= '0;
      exp_act <= exp_clamp(exp_stage);
    end else if (base_tick) begin
      pos <= pos + pre_t'(1);
    end
  end

  assign tick     = period_end & ~rst;
  assign rate_clk = ~rst & ((exp_act == '0) ? upper_half
                                            : ((pos & pre_half_mask(exp_act)) == '0));
endmodule

// File: rtl/twin_rate_gen.sv
module twin_rate_gen
  import twin_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [TC_W-1:0]  cfg_wdata,
  output logic             tx_tick,
  output logic             tx_clk,
  output logic             rx_tick,
  output logic             rx_clk
);
  logic [TC_W-1:0]  tc_stage;
  exp_t [N_DIR-1:0] exp_stage;
  exp_t [N_DIR-1:0] exp_act;
  logic [N_DIR-1:0] tick_v;
  logic [N_DIR-1:0] clk_v;
  logic             base_tick;
  logic             upper_half;
  ratio_t           tc_act;

  twin_rate_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .tc_stage(tc_stage), .exp_stage(exp_stage)
  );

  twin_tc_div u_div (
    .clk(clk), .rst(rst), .tc_stage(tc_stage),
    .base_tick(base_tick), .upper_half(upper_half), .tc_act(tc_act)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    twin_pow2_pre u_pre (
      .clk(clk), .rst(rst), .base_tick(base_tick), .upper_half(upper_half),
      .exp_stage(exp_stage[d]), .tick(tick_v[d]), .rate_clk(clk_v[d]),
      .exp_act(exp_act[d])
    );
  end

  assign tx_tick = tick_v[0];
  assign tx_clk  = clk_v[0];
  assign rx_tick = tick_v[1];
  assign rx_clk  = clk_v[1];
endmodule

// File: rtl/twin_rate_gen_chk.sv
module twin_rate_gen_chk
  import twin_rate_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tx_tick,
  input logic             tx_clk,
  input logic             rx_tick,
  input logic             rx_clk,
  input logic             base_tick,
  input ratio_t           tc_act,
  input exp_t [N_DIR-1:0] exp_act
);
  // R5: a strobe only ever coincides with a shared divider terminal count
  assert_strobe_on_terminal_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_tick || rx_tick) |-> base_tick);

  // R6: the rate clock is high in the first cycle of each period
  assert_tx_clk_high_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    tx_tick |=> tx_clk);
  assert_rx_clk_high_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    rx_tick |=> rx_clk);

  // R6: the rate clock is low in the strobe cycle unless the ratio is 1
  assert_tx_clk_low_at_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_tick && (exp_act[0] != '0 || tc_act != ratio_t'(1))) |-> !tx_clk);
  assert_rx_clk_low_at_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_tick && (exp_act[1] != '0 || tc_act != ratio_t'(1))) |-> !rx_clk);

  // R7: the active time constant moves only at a divider terminal
  assert_tc_held_R7: assert property (@(posedge clk) disable iff (rst)
    !base_tick |=> $stable(tc_act));

  // R8: an active exponent moves only at the end of its own period
  assert_tx_exp_held_R8: assert property (@(posedge clk) disable iff (rst)
    !tx_tick |=> $stable(exp_act[0]));
  assert_rx_exp_held_R8: assert property (@(posedge clk) disable iff (rst)
    !rx_tick |=> $stable(exp_act[1]));

  // R3: active exponents never exceed the clamp
  assert_exp_clamped_R3: assert property (@(posedge clk) disable iff (rst)
    (exp_act[0] <= exp_t'(EXP_MAX)) && (exp_act[1] <= exp_t'(EXP_MAX)));

  // R9: all outputs low while reset is held
  always @(negedge clk) begin
    if (rst) begin
      assert_quiet_in_reset_R9: assert (!tx_tick && !rx_tick && !tx_clk && !rx_clk);
    end
  end
endmodule

bind twin_rate_gen twin_rate_gen_chk u_chk (
  .clk(clk), .rst(rst), .tx_tick(tx_tick), .tx_clk(tx_clk),
  .rx_tick(rx_tick), .rx_clk(rx_clk), .base_tick(base_tick),
  .tc_act(tc_act), .exp_act(exp_act)
);

// File: tb/twin_rate_gen_test.sv
module twin_rate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam int LIMIT = 5000;
  // Stimulus: time constant field, tx exponent, rx exponent; expected periods.
  localparam int unsigned V_TC [NV] = '{1, 3, 5, 2, 1, 7,   0, 1};
  localparam int unsigned V_TXE[NV] = '{0, 1, 0, 4, 9, 2,   0, 12};
  localparam int unsigned V_RXE[NV] = '{0, 2, 3, 0, 15, 1,  1, 1};
  localparam int unsigned V_TXN[NV] = '{1, 6, 5, 32, 512, 28, 256, 512};
  localparam int unsigned V_RXN[NV] = '{1, 12, 40, 2, 512, 14, 512, 2};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic tx_tick, tx_clk, rx_tick, rx_clk;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  twin_rate_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .tx_tick(tx_tick), .tx_clk(tx_clk), .rx_tick(rx_tick), .rx_clk(rx_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit tick_of(input int d);
    return (d == 0) ? tx_tick : rx_tick;
  endfunction
  function automatic bit clk_of(input int d);
    return (d == 0) ? tx_clk : rx_clk;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [7:0] v);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Skip two strobes, then measure one whole period and its high cycles.
  task automatic measure(input int d, output int per, output int hi);
    int seen = 0;
    int guard = 0;
    per = 0; hi = 0;
    while (seen < 3 && guard < LIMIT) begin
      @(negedge clk);
      guard++;
      if (seen == 2) begin
        per++;
        if (clk_of(d)) hi++;
      end
      if (tick_of(d)) seen++;
    end
  endtask

  task automatic next_interval(input int d, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick_of(d) && n < LIMIT);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int per, hi, n, ntx, nrx;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 tx_tick in reset", int'(tx_tick), 0);
    check("R9 tx_clk in reset", int'(tx_clk), 0);
    check("R9 rx_tick/clk in reset", int'(rx_tick | rx_clk), 0);
    rst = 1'b0;
    ntx = 0; nrx = 0; n = 0;
    while ((ntx == 0 || nrx == 0) && n < LIMIT) begin
      @(negedge clk);
      n++;
      if (tx_tick && ntx == 0) ntx = n;
      if (rx_tick && nrx == 0) nrx = n;
    end
    check("R9 first tx strobe", ntx, 255);
    check("R9 first rx strobe", nrx, 255);

    // R1 R2 R3 R4 R5 R6: table of settings
    for (int i = 0; i < NV; i++) begin
      cfg_write(2'd0, 8'(V_TC[i]));
      cfg_write(2'd1, 8'(V_TXE[i]));
      cfg_write(2'd2, 8'(V_RXE[i]));
      measure(0, per, hi);
      check("R1/R5 tx period", per, int'(V_TXN[i]));
      check("R6 tx high time", hi, int'((V_TXN[i] + 1) / 2));
      measure(1, per, hi);
      check("R1/R5 rx period", per, int'(V_RXN[i]));
      check("R6 rx high time", hi, int'((V_RXN[i] + 1) / 2));
    end

    // R4: only tx exponent changes, rx keeps its period
    cfg_write(2'd0, 8'd3);
    cfg_write(2'd1, 8'd1);
    cfg_write(2'd2, 8'd2);
    measure(1, per, hi);
    check("R4 rx before", per, 12);
    cfg_write(2'd1, 8'd3);
    measure(0, per, hi);
    check("R4 tx after", per, 24);
    measure(1, per, hi);
    check("R4 rx unchanged", per, 12);

    // R10: select 3 is ignored
    cfg_write(2'd3, 8'd5);
    measure(0, per, hi);
    check("R10 tx unchanged", per, 24);
    measure(1, per, hi);
    check("R10 rx unchanged", per, 12);

    // R7: time constant change mid-cycle completes old count first
    cfg_write(2'd0, 8'd4);
    cfg_write(2'd1, 8'd0);
    measure(0, per, hi);
    check("R7 tx settled", per, 4);
    @(negedge clk);
    n = 1;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 8'd2;
    @(negedge clk);
    n = 2;
    cfg_we = 1'b0;
    while (!tx_tick && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    check("R7 period in progress", n, 4);
    next_interval(0, n);
    check("R7 new period", n, 2);

    // R8: exponent change mid-period completes the old period first
    cfg_write(2'd0, 8'd1);
    cfg_write(2'd1, 8'd2);
    measure(0, per, hi);
    check("R8 tx settled", per, 4);
    @(negedge clk);
    n = 1;
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'd0;
    @(negedge clk);
    n = 2;
    cfg_we = 1'b0;
    while (!tx_tick && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
    check("R8 period in progress", n, 4);
    next_interval(0, n);
    check("R8 new period", n, 1);

    // R9: reset mid-run restores defaults
    cfg_write(2'd0, 8'd3);
    cfg_write(2'd2, 8'd2);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 outputs low in mid-run reset", int'(tx_tick | tx_clk | rx_tick | rx_clk), 0);
    rst = 1'b0;
    measure(0, per, hi);
    check("R9 tx default period", per, 256);
    check("R9 tx default high", hi, 128);
    measure(1, per, hi);
    check("R9 rx default period", per, 256);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule